// File: doc/BRIEF.md
# Multi-Modulus Divider with 4/5 Prescaler

This block divides a half-rate clock by an integer modulus that may change on every output cycle. A dual-modulus prescaler counts four or five input periods per prescaler period. A segment controller splits each output cycle into three runs of prescaler periods. The first run is a fixed lead-in of five divide-by-4 periods. Then comes a computed run of divide-by-4 periods and, last, a computed run of divide-by-5 periods. The lengths of the two computed runs are chosen so that the whole cycle spans exactly the requested modulus.

The requested modulus is captured once per output cycle, fifteen input periods after the divided output rises. That point lies inside the fixed lead-in, so the computed run lengths are ready before they are needed. During the last prescaler period of a cycle the controller raises a pass flag. An edge-select flop latches that flag on the prescaler boundary that opens the next cycle. A retiming flop then copies the edge-select flop onto the input clock, and its output is the divided output.

The modulus must lie between `MIN_MOD` (36 by default) and the largest value that `MOD_W` bits can hold. The model is cycle-accurate at the input clock and carries no analog timing.

Top module: `mmd_divider`

## Requirements
- R1: While reset is high the output is low. After reset is released a new output cycle starts at the beginning of the lead-in, and the first output rising edge appears M+1 input clock edges after release, where M is the modulus presented at the first capture point.
- R2: The distance between consecutive output rising edges, counted in input clock edges, equals the modulus captured during the cycle that the earlier edge opens, for every modulus from 36 to 100.
- R3: The modulus input is sampled only on the 15th input clock edge after the edge on which the output rises. Values present on that input at any other edge have no effect on the output edge spacing.
- R4: Each output pulse stays high for exactly four input clock periods and is then low until the next rising edge.
- R5: The prescaler period lasts five input periods when the select is high and four when it is low. The select changes only at a prescaler boundary, and it is low throughout the five lead-in periods.
- R6: In each cycle of modulus M the number of divide-by-5 periods is (M-20) mod 4. The number of divide-by-4 periods after the lead-in is floor((M-20)/4) minus that value.
- R7: The edge-select flop sets only on a prescaler boundary, namely the one that follows a prescaler period during which the pass flag was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate input clock being divided |
| rst_i | input | 1 | Synchronous active-high reset |
| modulus_i | input | MOD_W | Requested modulus for the current output cycle, sampled once per cycle |
| div_o | output | 1 | Divided output, retimed to clk_i |

## Verification
An output rising edge is due two input clock edges after the end of a cycle: one edge for the edge-select flop and one for the retiming flop. So the bench expects the first rise on the 41st falling edge after reset release for a first modulus of 40, and every later rise exactly M falling edges after the previous one. The bench places a valid modulus on the input only for the one edge that is 15 edges after a rise. At every other edge it drives a different, decoy value, so sampling the input one edge early or late shows up as a wrong spacing. The pulse width is read on the first four falling edges after each rise. The modulus sweeps every value from 36 to 100 and then follows a pseudo-random sequence in the same range.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
   // Segment of the output cycle the controller is in
   typedef enum logic [1:0] {
      SEG_LEAD = 2'd0,
      SEG_FOUR = 2'd1,
      SEG_FIVE = 2'd2
   } mmd_seg_e;

   localparam int unsigned PS_W     = 3;  // prescaler phase counter width
   localparam int unsigned PS_SHORT = 4;  // input periods, select low
   localparam int unsigned PS_LONG  = 5;  // input periods, select high
endpackage

// File: rtl/mmd_prescaler.sv
module mmd_prescaler
   import mmd_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            sel_i,
   output logic [PS_W-1:0] phase_o,
   output logic            tick_o
);
   localparam logic [PS_W-1:0] LAST_SHORT = PS_W'(PS_SHORT - 1);
   localparam logic [PS_W-1:0] LAST_LONG  = PS_W'(PS_LONG - 1);

   logic [PS_W-1:0] phase_q;

   assign tick_o  = (phase_q == (sel_i ? LAST_LONG : LAST_SHORT));
   assign phase_o = phase_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       phase_q <= '0;
      else if (tick_o) phase_q <= '0;
      else             phase_q <= phase_q + 1'b1;
   end

   AST_SEL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i != $past(sel_i)) |-> $past(tick_o)); // R5
   AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      phase_q <= LAST_LONG); // R5
endmodule

// File: rtl/mmd_ctrl.sv
module mmd_ctrl
   import mmd_pkg::*;
#(
   parameter int unsigned MOD_W       = 8,
   parameter int unsigned LEAD_PERIODS = 5,
   parameter int unsigned LOAD_DELAY  = 15,
   parameter int unsigned MIN_MOD     = 36
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic [PS_W-1:0]  phase_i,
   input  logic [MOD_W-1:0] modulus_i,
   output logic             sel_o,
   output logic             pass_o,
   output mmd_seg_e         seg_o,
   output logic [MOD_W-1:0] mod_o
);
   localparam int unsigned LEAD_LEN = LEAD_PERIODS * PS_SHORT;
   localparam logic [MOD_W-1:0] LEAD_LAST = MOD_W'(LEAD_PERIODS - 1);
   localparam logic [MOD_W-1:0] LOAD_PER  = MOD_W'(LOAD_DELAY / PS_SHORT);
   localparam logic [PS_W-1:0]  LOAD_PH   = PS_W'(LOAD_DELAY % PS_SHORT);

   mmd_seg_e         seg_q;
   logic [MOD_W-1:0] per_q;
   logic [MOD_W-1:0] mod_q;
   logic [MOD_W-1:0] excess;
   logic [MOD_W-1:0] num_five;
   logic [MOD_W-1:0] num_four;
   logic             load_en;
   logic             four_done;
   logic             five_done;

   // Split the part beyond the lead-in into /4 and /5 runs
   assign excess   = mod_q - MOD_W'(LEAD_LEN);
   assign num_five = MOD_W'(excess[1:0]);
   assign num_four = (excess >> 2) - num_five;

   assign load_en   = (seg_q == SEG_LEAD) && (per_q == LOAD_PER) && (phase_i == LOAD_PH);
   assign four_done = (per_q == num_four - 1'b1);
   assign five_done = (per_q == num_five - 1'b1);

   always_ff @(posedge clk_i) begin
      if (rst_i)        mod_q <= MOD_W'(MIN_MOD);
      else if (load_en) mod_q <= modulus_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         seg_q <= SEG_LEAD;
         per_q <= '0;
      end else if (tick_i) begin
         unique case (seg_q)
            SEG_LEAD: begin
               if (per_q == LEAD_LAST) begin
                  seg_q <= SEG_FOUR;
                  per_q <= '0;
               end else begin
                  per_q <= per_q + 1'b1;
               end
            end
            SEG_FOUR: begin
               if (four_done) begin
                  seg_q <= (num_five == '0) ? SEG_LEAD : SEG_FIVE;
                  per_q <= '0;
               end else begin
                  per_q <= per_q + 1'b1;
               end
            end
            SEG_FIVE: begin
               if (five_done) begin
                  seg_q <= SEG_LEAD;
                  per_q <= '0;
               end else begin
                  per_q <= per_q + 1'b1;
               end
            end
            default: begin
               seg_q <= SEG_LEAD;
               per_q <= '0;
            end
         endcase
      end
   end

   assign sel_o  = (seg_q == SEG_FIVE);
   assign pass_o = ((seg_q == SEG_FOUR) && four_done && (num_five == '0)) ||
                   ((seg_q == SEG_FIVE) && five_done);
   assign seg_o  = seg_q;
   assign mod_o  = mod_q;

   AST_LOAD_BEFORE_SPLIT: assert property (@(posedge clk_i) disable iff (rst_i)
      (seg_q == SEG_FOUR) |-> $stable(mod_q)); // R3
endmodule

// File: rtl/mmd_edge.sv
module mmd_edge (
   input  logic clk_i,
   input  logic rst_i,
   input  logic tick_i,
   input  logic pass_i,
   output logic esel_o,
   output logic div_o
);
   logic esel_q;
   logic div_q;

   // Edge select follows the pass flag at prescaler boundaries
   always_ff @(posedge clk_i) begin
      if (rst_i)       esel_q <= 1'b0;
      else if (tick_i) esel_q <= pass_i;
   end

   // Retime onto the input clock
   always_ff @(posedge clk_i) begin
      if (rst_i) div_q <= 1'b0;
      else       div_q <= esel_q;
   end

   assign esel_o = esel_q;
   assign div_o  = div_q;

   AST_ESEL_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(esel_q) |-> ($past(tick_i) && $past(pass_i))); // R7
   AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(div_q) |=> div_q ##1 div_q ##1 div_q ##1 !div_q); // R4
endmodule

// File: rtl/mmd_divider.sv
module mmd_divider
   import mmd_pkg::*;
#(
   parameter int unsigned MOD_W        = 8,
   parameter int unsigned LEAD_PERIODS = 5,
   parameter int unsigned LOAD_DELAY   = 15,
   parameter int unsigned MIN_MOD      = 36
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [MOD_W-1:0] modulus_i,
   output logic             div_o
);
   localparam int unsigned LEAD_LEN = LEAD_PERIODS * PS_SHORT;
   localparam int unsigned MOD_MAX  = (1 << MOD_W) - 1;

   generate
      if (MIN_MOD < LEAD_LEN + 4 * PS_SHORT) begin : g_bad_min
         $error("MIN_MOD too small to leave a nonempty divide-by-4 run");
      end
      if (LOAD_DELAY >= LEAD_LEN) begin : g_bad_load
         $error("LOAD_DELAY must fall inside the lead-in");
      end
      if (MIN_MOD > MOD_MAX) begin : g_bad_width
         $error("MOD_W cannot hold MIN_MOD");
      end
   endgenerate

   logic             sel;
   logic             tick;
   logic             pass;
   logic             esel;
   logic [PS_W-1:0]  phase;
   mmd_seg_e         seg;
   logic [MOD_W-1:0] mod_cur;

   mmd_prescaler u_pre (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sel_i   (sel),
      .phase_o (phase),
      .tick_o  (tick)
   );

   mmd_ctrl #(
      .MOD_W        (MOD_W),
      .LEAD_PERIODS (LEAD_PERIODS),
      .LOAD_DELAY   (LOAD_DELAY),
      .MIN_MOD      (MIN_MOD)
   ) u_ctrl (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .tick_i    (tick),
      .phase_i   (phase),
      .modulus_i (modulus_i),
      .sel_o     (sel),
      .pass_o    (pass),
      .seg_o     (seg),
      .mod_o     (mod_cur)
   );

   mmd_edge u_edge (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_i (tick),
      .pass_i (pass),
      .esel_o (esel),
      .div_o  (div_o)
   );

   // Cycle checker: input periods and /5 periods since the cycle began
   logic [MOD_W-1:0] chk_len;
   logic [MOD_W-1:0] chk_five;
   logic             cyc_end;

   assign cyc_end = tick && pass;

   always_ff @(posedge clk_i) begin
      if (rst_i || cyc_end) begin
         chk_len  <= '0;
         chk_five <= '0;
      end else begin
         chk_len  <= chk_len + 1'b1;
         chk_five <= chk_five + MOD_W'(tick && sel);
      end
   end

   AST_CYCLE_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
      cyc_end |-> (chk_len + 1'b1 == mod_cur)); // R2
   AST_FIVE_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
      cyc_end |-> (chk_five + MOD_W'(sel) == MOD_W'((mod_cur - MOD_W'(LEAD_LEN)) & 2'd3))); // R6
   AST_LEAD_DIV4: assert property (@(posedge clk_i) disable iff (rst_i)
      (seg == SEG_LEAD) |-> (phase <= PS_W'(PS_SHORT - 1))); // R5
   AST_ESEL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !tick |=> $stable(esel)); // R7
endmodule

// File: tb/mmd_divider_tb.sv
module mmd_divider_tb;
   localparam int unsigned MOD_W = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [MOD_W-1:0] mod_in = '0;
   logic             div_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   mmd_divider #(.MOD_W(MOD_W)) u_dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .modulus_i (mod_in),
      .div_o     (div_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [MOD_W-1:0] decoy(input int m);
      return (m >= 90) ? MOD_W'(37) : MOD_W'(99);
   endfunction

   // Called on the falling edge where a rise was seen; runs one cycle of modulus m
   task automatic run_cycle(input int m);
      int  gap = 0;
      bit  high_ok = 1'b1;
      logic prev = 1'b1;
      mod_in = decoy(m);
      for (int k = 1; k <= 400; k++) begin
         @(negedge clk);
         mod_in = (k == 14) ? MOD_W'(m) : decoy(m);  // R3: valid only at the capture edge
         if (k <= 3 && !div_out) high_ok = 1'b0;
         if (k == 4) check(high_ok && !div_out, "R4", {30'd0, high_ok, div_out}, 2);
         if (div_out && !prev) begin
            gap = k;
            break;
         end
         prev = div_out;
      end
      // R2 R3 R5 R6: spacing equals the captured modulus
      check(gap == m, "R2", gap, m);
   endtask

   initial begin
      logic [7:0] lfsr = 8'hA5;
      int first = 0;
      repeat (5) @(negedge clk);
      check(div_out == 1'b0, "R1", int'(div_out), 0);
      mod_in = MOD_W'(40);
      rst = 1'b0;
      for (int k = 1; k <= 200; k++) begin
         @(negedge clk);
         if (div_out) begin
            first = k;
            break;
         end
      end
      check(first == 41, "R1", first, 41);
      for (int m = 36; m <= 100; m++) run_cycle(m);
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         run_cycle(36 + int'(lfsr) % 65);
      end
      // R1: reset mid-cycle forces the output low and restarts the cycle
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(div_out == 1'b0, "R1", int'(div_out), 0);
      mod_in = MOD_W'(57);
      rst = 1'b0;
      first = 0;
      for (int k = 1; k <= 200; k++) begin
         @(negedge clk);
         if (div_out) begin
            first = k;
            break;
         end
      end
      check(first == 58, "R1", first, 58);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule